// File: doc/BRIEF.md
# Receive Frame Filter and Descriptor Writer

This block sits behind a receive MAC and consumes its byte stream. Each frame is held in an internal byte buffer until its last byte arrives. Only then does the block decide whether to keep the frame. The decision rests on three things: the global enables, the frame length, and the destination address carried in the first six bytes. The destination can match broadcast, multicast, or the station's own unicast address.

For a kept frame, the block works through a descriptor in system memory. A descriptor is three 32-bit words at consecutive word addresses:

| Offset | Contents |
|--------|----------|
| +0 | Buffer address |
| +4 | Size/status word |
| +8 | Next-descriptor pointer |

The block reads the size word first.

- **Bit 31 set (empty):** the block writes the frame into the buffer, rewrites the size word with the frame length, pulses a received event and follows the next pointer.
- **Bit 31 clear:** the block drops the frame, clears its own DMA-active state and pulses an overflow event.

Software re-arms the engine by pulsing `dma_arm`, which loads the current descriptor pointer.

Top module: `rx_frame_sink`

## Requirements
- R1: A frame is kept only if `rx_mac_en` is 1 and `dma_active` is 1 when its last byte is accepted; otherwise it is dropped.
- R2: A frame is dropped if its length in bytes exceeds `max_len`, or exceeds the buffer capacity BUF_BYTES (default 2047).
- R3: The all-ones destination is broadcast. It is kept if `bc_dontcare` is 1, dropped if instead `bc_drop` is 1, and kept if both are 0.
- R4: Any other destination whose first byte has bit 0 set is multicast. It follows the same rule using `mc_dontcare` and `mc_drop`.
- R5: Any other destination is kept only if it equals the station address. Octets 1..4 come from `station_hi[31:24]` down to `[7:0]`, and octets 5..6 from `station_lo[31:24]` and `[23:16]`.
- R6: A one-cycle `dma_arm` pulse sets `dma_active` and loads the current descriptor pointer from `dma_desc_base` with bits 1:0 forced to 0.
- R7: When the size word (descriptor +4) has bit 31 set, the frame is written to the buffer address taken from descriptor +0 with bits 1:0 cleared. Byte i of the frame goes to word i/4, bits 8*(i%4)+7 : 8*(i%4). Bytes past the frame end in the last word are 0.
- R8: After the data, the size word is written with the length in bits 10:0 and all other bits 0. `evt_rcvd` then pulses for one cycle, and the pointer advances to descriptor +8 with bits 1:0 cleared.
- R9: When the size word has bit 31 clear, nothing is written, `dma_active` clears and `evt_ovf` pulses for one cycle.
- R10: A dropped frame causes no memory access and no event.
- R11: `s_ready` is low from the edge that accepts a kept frame's last byte until its descriptor work ends. `mem_req` holds, with a stable address, until `mem_ack`.
- R12: After reset, `dma_active` is 0, `mem_req` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mac_en | input | 1 | MAC receive enable |
| dma_arm | input | 1 | Pulse: load descriptor pointer, set DMA active |
| dma_desc_base | input | AW | First descriptor address |
| dma_active | output | 1 | Receive DMA enabled state |
| station_hi | input | 32 | Station address octets 1..4 |
| station_lo | input | 32 | Station address octets 5..6 in bits 31:16 |
| bc_dontcare | input | 1 | Broadcast always kept |
| bc_drop | input | 1 | Broadcast dropped unless don't-care |
| mc_dontcare | input | 1 | Multicast always kept |
| mc_drop | input | 1 | Multicast dropped unless don't-care |
| max_len | input | 16 | Longest frame kept, in bytes |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_ready | output | 1 | Block can take a byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| evt_rcvd | output | 1 | Frame stored pulse |
| evt_ovf | output | 1 | No empty descriptor pulse |

## Verification
The assertions assume that `mem_ack` arrives only while `mem_req` is high and never in two back-to-back cycles. The bench's memory model raises `mem_ack` exactly one cycle after it first sees a request and drops it the next cycle, so every access takes two cycles. The assertions also assume `dma_arm` is a single-cycle pulse. The bench drives it for one cycle, between frames and never while descriptor work is in progress.

// File: rtl/rx_frame_sink.sv
module rx_frame_sink #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 2047
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_mac_en,
  input  logic          dma_arm,
  input  logic [AW-1:0] dma_desc_base,
  output logic          dma_active,
  input  logic [31:0]   station_hi,
  input  logic [31:0]   station_lo,
  input  logic          bc_dontcare,
  input  logic          bc_drop,
  input  logic          mc_dontcare,
  input  logic          mc_drop,
  input  logic [15:0]   max_len,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          evt_rcvd,
  output logic          evt_ovf
);
  localparam int IW = $clog2(BUF_BYTES + 1);
  localparam int WW = IW - 2;

  typedef enum logic [2:0] {S_RECV, S_RD_SIZE, S_RD_BUF, S_RD_NEXT, S_WR_DATA, S_WR_SIZE} st_t;
  st_t state;

  logic [7:0]    fbuf [BUF_BYTES];
  logic [15:0]   cnt;
  logic [47:0]   dest, dest_nx;
  logic [AW-1:0] cur_ptr, buf_ptr, nxt_ptr;
  logic [IW-1:0] frame_len;
  logic [WW-1:0] widx;
  logic [16:0]   len_now;
  logic [31:0]   word_out;
  logic          beat, is_bc, is_mc, addr_ok, keep, last_word;
  logic [AW-1:0] rd_ptr;

  assign s_ready = (state == S_RECV);
  assign beat    = s_valid && s_ready;
  assign len_now = {1'b0, cnt} + 17'd1;
  assign dest_nx = (beat && cnt < 16'd6) ? (dest | ({s_data, 40'd0} >> {cnt[2:0], 3'b000})) : dest;

  assign is_bc   = (dest_nx == 48'hFFFF_FFFF_FFFF);
  assign is_mc   = dest_nx[40];
  assign addr_ok = is_bc ? (bc_dontcare || !bc_drop)
                 : is_mc ? (mc_dontcare || !mc_drop)
                 : (dest_nx == {station_hi, station_lo[31:16]});
  assign keep    = rx_mac_en && dma_active && addr_ok &&
                   (len_now <= {1'b0, max_len}) && (len_now <= 17'(BUF_BYTES));

  assign rd_ptr  = AW'(mem_rdata & ~32'd3);
  assign last_word = ({1'b0, widx, 2'b00} + (IW+1)'(4)) >= {1'b0, frame_len};

  always_comb begin
    word_out = '0;
    for (int b = 0; b < 4; b++) begin
      logic [IW-1:0] idx;
      idx = {widx, 2'(b)};
      if (idx < frame_len) word_out[8*b +: 8] = fbuf[idx];
    end
  end

  assign mem_req = (state != S_RECV);
  assign mem_we  = (state == S_WR_DATA) || (state == S_WR_SIZE);
  always_comb begin
    case (state)
      S_RD_BUF:  mem_addr = cur_ptr;
      S_RD_NEXT: mem_addr = cur_ptr + AW'(8);
      S_WR_DATA: mem_addr = buf_ptr + AW'({widx, 2'b00});
      default:   mem_addr = cur_ptr + AW'(4);
    endcase
  end
  assign mem_wdata = (state == S_WR_SIZE) ? 32'(frame_len) : word_out;

  always_ff @(posedge clk) begin
    if (beat && cnt < 16'(BUF_BYTES)) fbuf[cnt[IW-1:0]] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_RECV;
      cnt        <= '0;
      dest       <= '0;
      cur_ptr    <= '0;
      buf_ptr    <= '0;
      nxt_ptr    <= '0;
      frame_len  <= '0;
      widx       <= '0;
      dma_active <= 1'b0;
      evt_rcvd   <= 1'b0;
      evt_ovf    <= 1'b0;
    end else begin
      evt_rcvd <= 1'b0;
      evt_ovf  <= 1'b0;
      case (state)
        S_RECV: if (beat) begin
          if (s_last) begin
            cnt  <= '0;
            dest <= '0;
            if (keep) begin
              frame_len <= len_now[IW-1:0];
              state     <= S_RD_SIZE;
            end
          end else begin
            cnt  <= (cnt == 16'hFFFF) ? cnt : cnt + 16'd1;
            dest <= dest_nx;
          end
        end
        S_RD_SIZE: if (mem_ack) begin
          if (mem_rdata[31]) state <= S_RD_BUF;
          else begin
            dma_active <= 1'b0;
            evt_ovf    <= 1'b1;
            state      <= S_RECV;
          end
        end
        S_RD_BUF: if (mem_ack) begin
          buf_ptr <= rd_ptr;
          state   <= S_RD_NEXT;
        end
        S_RD_NEXT: if (mem_ack) begin
          nxt_ptr <= rd_ptr;
          widx    <= '0;
          state   <= S_WR_DATA;
        end
        S_WR_DATA: if (mem_ack) begin
          if (last_word) state <= S_WR_SIZE;
          else widx <= widx + WW'(1);
        end
        S_WR_SIZE: if (mem_ack) begin
          cur_ptr  <= nxt_ptr;
          evt_rcvd <= 1'b1;
          state    <= S_RECV;
        end
        default: state <= S_RECV;
      endcase
      if (dma_arm) begin
        dma_active <= 1'b1;
        cur_ptr    <= dma_desc_base & ~AW'(3);
      end
    end
  end

  // R11: a request is held with a stable address until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R11: no stream bytes are taken while memory work is pending
  a_r11_no_beat_in_dma: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !s_ready);
  // R9: overflow leaves the engine disabled unless re-armed at that edge
  a_r9_ovf_disables: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf && !$past(dma_arm) |-> !dma_active);
  // R8: a received event follows an acknowledged write
  a_r8_rcvd_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_rcvd) |-> $past(mem_req && mem_we && mem_ack));
  // R9: overflow follows an acknowledged read, never a write
  a_r9_ovf_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_ovf) |-> $past(mem_req && !mem_we && mem_ack));
  // R8/R9: the two events are exclusive
  a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_rcvd, evt_ovf}));
  // R7: every memory access is word aligned
  a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

// File: tb/sim_rx_frame_sink.sv
module sim_rx_frame_sink;
  logic clk = 0, rst_n = 0;
  logic rx_mac_en = 0, dma_arm = 0;
  logic [31:0] dma_desc_base = 0;
  logic dma_active;
  logic [31:0] station_hi = 32'h0211_2233, station_lo = 32'h4455_0000;
  logic bc_dontcare = 0, bc_drop = 0, mc_dontcare = 0, mc_drop = 0;
  logic [15:0] max_len = 16'h0600;
  logic s_valid = 0, s_last = 0, s_ready;
  logic [7:0] s_data = 0;
  logic mem_req, mem_we, mem_ack = 0, evt_rcvd, evt_ovf;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;

  always #2.5 clk = ~clk;

  rx_frame_sink u0 (.*);

  logic [31:0] mem [1024];
  int n_wr = 0, n_rcvd = 0, n_ovf = 0, n_acc = 0;
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      n_acc   <= n_acc + 1;
      if (mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; n_wr <= n_wr + 1; end
      else mem_rdata <= mem[mem_addr[11:2]];
    end
    if (evt_rcvd) n_rcvd <= n_rcvd + 1;
    if (evt_ovf)  n_ovf  <= n_ovf + 1;
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %h expected %h", req, act, exp); end
  endtask

  logic [7:0] fb [64];
  logic rdy_after;
  int k_next = 0;

  task automatic build(input logic [47:0] d, input int n);
    for (int i = 0; i < n; i++) fb[i] = (i < 6) ? d[8*(5-i) +: 8] : 8'(i*7 + 3);
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!s_ready) @(negedge clk);
      s_valid = 1; s_data = fb[i]; s_last = (i == n-1);
      @(posedge clk);
    end
    @(negedge clk);
    rdy_after = s_ready;
    s_valid = 0; s_last = 0;
    while (!s_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] base);
    @(negedge clk); dma_desc_base = base; dma_arm = 1;
    @(negedge clk); dma_arm = 0;
  endtask

  task automatic expect_kept(input int n, input string req);
    int a, b;
    logic [31:0] w;
    a = 32'h100 + 16*k_next; b = 32'h400 + 128*k_next;
    chk(rdy_after == 0, "R11 ready low after kept last", 32'(rdy_after), 0);
    chk(mem[(a>>2)+1] == 32'(n), {req, " size word"}, mem[(a>>2)+1], 32'(n));
    for (int wi = 0; wi < (n+3)/4; wi++) begin
      w = 0;
      for (int j = 0; j < 4; j++) if (4*wi+j < n) w[8*j +: 8] = fb[4*wi+j];
      chk(mem[(b>>2)+wi] == w, {req, " R7 data word"}, mem[(b>>2)+wi], w);
    end
    k_next++;
  endtask

  task automatic kept(input logic [47:0] d, input int n, input string req);
    int r0;
    r0 = n_rcvd;
    build(d, n); send(n);
    chk(n_rcvd == r0 + 1, {req, " R8 rcvd event"}, 32'(n_rcvd), 32'(r0+1));
    expect_kept(n, req);
  endtask

  task automatic dropped(input logic [47:0] d, input int n, input string req);
    int a0, r0, o0;
    a0 = n_acc; r0 = n_rcvd; o0 = n_ovf;
    build(d, n); send(n);
    chk(n_acc == a0, {req, " R10 no memory access"}, 32'(n_acc), 32'(a0));
    chk(n_rcvd == r0 && n_ovf == o0, {req, " R10 no event"}, 32'(n_rcvd + n_ovf), 32'(r0 + o0));
  endtask

  localparam logic [47:0] ME = 48'h0211_2233_4455;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;

  task automatic t_reset;
    chk(dma_active == 0 && mem_req == 0 && s_ready == 1, "R12 reset state",
        {29'd0, dma_active, mem_req, s_ready}, 32'd1);
  endtask

  task automatic t_unicast;
    kept(ME, 10, "R5 R6 unicast to armed descriptor");
    kept(ME, 13, "R8 advance to next descriptor");
    dropped(48'h0211_2233_4456, 12, "R5 foreign unicast");
  endtask

  task automatic t_bcast;
    bc_drop = 1; dropped(BC, 9, "R3 broadcast drop");
    bc_dontcare = 1; kept(BC, 9, "R3 broadcast dontcare beats drop");
    bc_drop = 0; bc_dontcare = 0; kept(BC, 11, "R3 broadcast default");
  endtask

  task automatic t_mcast;
    mc_drop = 1; dropped(MC, 8, "R4 multicast drop");
    bc_dontcare = 1; dropped(MC, 8, "R4 broadcast bits do not cover multicast");
    bc_dontcare = 0; mc_dontcare = 1; kept(MC, 7, "R4 multicast dontcare");
    mc_drop = 0; mc_dontcare = 0;
  endtask

  task automatic t_length;
    max_len = 16'd8;
    dropped(ME, 9, "R2 one over max length");
    kept(ME, 8, "R2 exactly max length");
    max_len = 16'h0600;
  endtask

  task automatic t_enable;
    rx_mac_en = 0; dropped(ME, 10, "R1 mac receive disabled");
    rx_mac_en = 1;
  endtask

  task automatic t_overflow;
    int w0, o0;
    arm(32'h200);
    w0 = n_wr; o0 = n_ovf;
    build(ME, 10); send(10);
    chk(n_ovf == o0 + 1, "R9 overflow event", 32'(n_ovf), 32'(o0+1));
    chk(dma_active == 0, "R9 dma disabled", 32'(dma_active), 0);
    chk(n_wr == w0, "R9 no writes", 32'(n_wr), 32'(w0));
    chk(mem[(32'h200>>2)+1] == 32'h0000_0123, "R9 descriptor untouched",
        mem[(32'h200>>2)+1], 32'h0000_0123);
    dropped(ME, 10, "R1 dma inactive after overflow");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    for (int k = 0; k < 8; k++) begin
      mem[(32'h100 + 16*k) >> 2]       = 32'h400 + 128*k + 3;
      mem[((32'h100 + 16*k) >> 2) + 1] = 32'h8000_0000;
      mem[((32'h100 + 16*k) >> 2) + 2] = 32'h100 + 16*(k+1) + 2;
    end
    mem[(32'h200 >> 2) + 1] = 32'h0000_0123;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    rx_mac_en = 1;
    arm(32'h103);
    chk(dma_active == 1, "R6 arm sets active", 32'(dma_active), 1);
    t_unicast;
    t_bcast;
    t_mcast;
    t_length;
    t_enable;
    t_overflow;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule